// File: doc/BRIEF.md
# Two-Segment Bus Slot Arbiter

This block is the media-access timing core of one node on a time-triggered bus. Every bus cycle has a static segment and then a dynamic segment, and the two repeat forever. The static segment holds a configured number of slots, all of one configured length in clock ticks. The dynamic segment is a configured number of minislots of one configured tick length. A dynamic slot that carries no frame lasts one minislot. A dynamic slot that carries a frame lasts as many minislots as the frame needs.

The block counts cycles, static slots, dynamic slots and minislots. It compares the active slot number with the node's own frame identifiers, and raises a static or dynamic transmit grant for the duration of the owned slot. A dynamic frame may start only while the minislot count is below the node's latest-start limit. Otherwise it waits for a later cycle, and the slot passes as an idle minislot.

The surrounding controller reads the grants and the slot-start pulses to drive its framer. It keeps the configuration stable while the block runs.

Top module: `tt_slot_arbiter`

## Requirements
- R1: While reset is high and on the first sample after it, the counters read as follows: cycle 0, static slot 1, dynamic slot 1, minislot 1. Every grant, pulse and flag is 0, and `in_dynamic` is 0.
- R2: Each static slot lasts `cfg_slot_len` ticks, with 0 treated as 1. Static slots are numbered 1 up to `cfg_num_static`, and then the dynamic segment begins with `in_dynamic` high.
- R3: Each minislot lasts `cfg_minislot_len` ticks, with 0 treated as 1. After `cfg_num_minislots` minislots, or straight after the static segment when that count is 0, a new cycle starts. The cycle counter then increases by one and wraps from 63 to 0; the first cycle after reset keeps the value 0.
- R4: At every cycle start, `cycle_start` pulses for one tick, and the static slot, dynamic slot and minislot counters all return to 1.
- R5: `st_grant` is high for the whole of a static slot whose number equals a nonzero entry of `st_ids` (packed 4 entries of `SLOT_W` bits, entry i at bits [i*SLOT_W +: SLOT_W]). It is low at every other time.
- R6: A dynamic slot with no granted frame lasts exactly one minislot. The dynamic slot counter then increments.
- R7: A dynamic slot starts a frame when all three of these hold: its number equals a nonzero entry i of `dy_ids` (same packing as `st_ids`), `dy_pending[i]` is high, and the minislot count at slot start is below `cfg_latest_tx`. `dy_grant` then stays high for `dy_frame_len` minislots, sampled at slot start with 0 treated as 1. Both the minislot and the dynamic slot counters run during the frame, and the dynamic slot counter increments when the frame ends.
- R8: A matching, pending dynamic slot whose minislot count is not below `cfg_latest_tx` gives no grant. It pulses `dy_defer` with the slot start and lasts one minislot.
- R9: `st_slot_start` pulses for one tick at the start of each static slot, and `dy_slot_start` pulses for one tick at the start of each dynamic slot.
- R10: While `cfg_num_static` is 0, `cfg_err` is high one tick later. If the block has not started a cycle yet, it stays in its reset counter state with no pulses or grants, and it begins a cycle on the tick after the count becomes nonzero.
- R11: A dynamic frame still running when the dynamic segment ends is cut off: `dy_grant` falls at the cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_slot_len | input | TICK_W | Static slot length in ticks |
| cfg_num_static | input | SLOT_W | Number of static slots per cycle |
| cfg_num_minislots | input | MS_W | Dynamic segment length in minislots |
| cfg_minislot_len | input | TICK_W | Minislot length in ticks |
| cfg_latest_tx | input | MS_W | Latest-start limit for dynamic frames |
| st_ids | input | N_ST*SLOT_W | Node's static frame identifiers, 0 = unused |
| dy_ids | input | N_DY*SLOT_W | Node's dynamic frame identifiers, 0 = unused |
| dy_pending | input | N_DY | A message waits for dynamic identifier i |
| dy_frame_len | input | MS_W | Length in minislots of a frame granted now |
| cycle_cnt | output | CYC_W | Bus cycle counter |
| st_slot | output | SLOT_W | Static slot counter |
| dy_slot | output | SLOT_W | Dynamic slot counter |
| minislot | output | MS_W | Minislot counter |
| in_dynamic | output | 1 | Dynamic segment active |
| st_grant | output | 1 | Static transmit grant |
| dy_grant | output | 1 | Dynamic transmit grant |
| cycle_start | output | 1 | One-tick pulse at cycle start |
| st_slot_start | output | 1 | One-tick pulse at static slot start |
| dy_slot_start | output | 1 | One-tick pulse at dynamic slot start |
| dy_defer | output | 1 | Dynamic frame held back by the latest-start limit |
| cfg_err | output | 1 | Static slot count configured as zero |

## Verification
On every cycle the assertions check the following: the two grants never overlap; counters are reset at each cycle start; the cycle count advances by one from one cycle start to the next; a dynamic grant rises only on a dynamic slot start below the latest-start limit; a deferral never comes with a grant; and the configuration-error state stays quiet. Only the bench's scenarios can show the exact tick on which each slot and minislot ends, how long frames last, truncation at the segment end, and the 63-to-0 wrap. The bench compares every output on every tick against its own cycle model.

// File: rtl/tt_arb_pkg.sv
package tt_arb_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_ST   = 2'd1,
    PH_DY   = 2'd2
  } phase_e;
endpackage

// File: rtl/tt_tick_timer.sv
// Counts ticks inside one slot or minislot; last marks its final tick.
module tt_tick_timer #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [TICK_W-1:0] len,
  output logic              last
);
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] len_m1;

  assign len_m1 = (len == '0) ? '0 : len - 1'b1;
  assign last   = !restart && (cnt >= len_m1);

  always_ff @(posedge clk) begin
    if (rst || restart || last) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tt_id_match.sv
// Compares one slot number with a packed list of owned identifiers.
module tt_id_match #(
  parameter int N = 4,
  parameter int W = 6
) (
  input  logic [N*W-1:0] ids,
  input  logic [N-1:0]   en,
  input  logic [W-1:0]   slot,
  output logic           hit
);
  logic [N-1:0] each_hit;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign each_hit[i] = en[i] && (ids[i*W +: W] != '0) && (ids[i*W +: W] == slot);
  end

  assign hit = |each_hit;
endmodule

// File: rtl/tt_slot_arbiter.sv
module tt_slot_arbiter #(
  parameter int TICK_W = 8,
  parameter int SLOT_W = 6,
  parameter int MS_W   = 8,
  parameter int CYC_W  = 6,
  parameter int N_ST   = 4,
  parameter int N_DY   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [TICK_W-1:0]    cfg_slot_len,
  input  logic [SLOT_W-1:0]    cfg_num_static,
  input  logic [MS_W-1:0]      cfg_num_minislots,
  input  logic [TICK_W-1:0]    cfg_minislot_len,
  input  logic [MS_W-1:0]      cfg_latest_tx,
  input  logic [N_ST*SLOT_W-1:0] st_ids,
  input  logic [N_DY*SLOT_W-1:0] dy_ids,
  input  logic [N_DY-1:0]      dy_pending,
  input  logic [MS_W-1:0]      dy_frame_len,
  output logic [CYC_W-1:0]     cycle_cnt,
  output logic [SLOT_W-1:0]    st_slot,
  output logic [SLOT_W-1:0]    dy_slot,
  output logic [MS_W-1:0]      minislot,
  output logic                 in_dynamic,
  output logic                 st_grant,
  output logic                 dy_grant,
  output logic                 cycle_start,
  output logic                 st_slot_start,
  output logic                 dy_slot_start,
  output logic                 dy_defer,
  output logic                 cfg_err
);
  import tt_arb_pkg::*;

  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);
  localparam logic [MS_W-1:0]   MS_ONE   = MS_W'(1);

  phase_e              phase, n_phase;
  logic                started, n_started;
  logic [MS_W-1:0]     rem, n_rem;
  logic [CYC_W-1:0]    n_cyc;
  logic [SLOT_W-1:0]   n_st, n_dy;
  logic [MS_W-1:0]     n_ms;
  logic                n_sg, n_dg, n_cs, n_sss, n_dss, n_def;
  logic                go_cycle, go_dyn;

  // Timer: length follows the active segment
  logic              tmr_last;
  logic [TICK_W-1:0] tmr_len;
  assign tmr_len = (phase == PH_DY) ? cfg_minislot_len : cfg_slot_len;

  tt_tick_timer #(.TICK_W(TICK_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (phase == PH_WAIT),
    .len     (tmr_len),
    .last    (tmr_last)
  );

  // Slot numbers a starting slot would take
  logic [SLOT_W-1:0] st_probe, dy_probe;
  logic [MS_W-1:0]   ms_probe;
  assign st_probe = (phase == PH_ST && st_slot != cfg_num_static) ? st_slot + 1'b1 : SLOT_ONE;
  assign dy_probe = (phase == PH_DY) ? dy_slot + 1'b1 : SLOT_ONE;
  assign ms_probe = (phase == PH_DY) ? minislot + 1'b1 : MS_ONE;

  logic st_hit, dy_hit, dy_ok;
  logic [MS_W-1:0] flen_c;

  tt_id_match #(.N(N_ST), .W(SLOT_W)) u_st_match (
    .ids  (st_ids),
    .en   ({N_ST{1'b1}}),
    .slot (st_probe),
    .hit  (st_hit)
  );

  tt_id_match #(.N(N_DY), .W(SLOT_W)) u_dy_match (
    .ids  (dy_ids),
    .en   (dy_pending),
    .slot (dy_probe),
    .hit  (dy_hit)
  );

  assign dy_ok  = ms_probe < cfg_latest_tx;
  assign flen_c = (dy_frame_len == '0) ? MS_ONE : dy_frame_len;

  always_comb begin
    n_phase   = phase;
    n_started = started;
    n_rem     = rem;
    n_cyc     = cycle_cnt;
    n_st      = st_slot;
    n_dy      = dy_slot;
    n_ms      = minislot;
    n_sg      = st_grant;
    n_dg      = dy_grant;
    n_cs      = 1'b0;
    n_sss     = 1'b0;
    n_dss     = 1'b0;
    n_def     = 1'b0;
    go_cycle  = 1'b0;
    go_dyn    = 1'b0;
    unique case (phase)
      PH_WAIT: go_cycle = (cfg_num_static != '0);
      PH_ST: begin
        if (tmr_last) begin
          if (st_slot == cfg_num_static) begin
            n_sg = 1'b0;
            if (cfg_num_minislots == '0) go_cycle = 1'b1;
            else begin
              n_phase = PH_DY;
              go_dyn  = 1'b1;
            end
          end else begin
            n_st  = st_probe;
            n_sss = 1'b1;
            n_sg  = st_hit;
          end
        end
      end
      PH_DY: begin
        if (tmr_last) begin
          if (minislot == cfg_num_minislots) begin
            n_dg     = 1'b0;
            go_cycle = 1'b1;
          end else begin
            n_ms = ms_probe;
            if (rem <= MS_ONE) go_dyn = 1'b1;
            else               n_rem  = rem - 1'b1;
          end
        end
      end
      default: n_phase = PH_WAIT;
    endcase
    if (go_dyn) begin
      n_dy  = dy_probe;
      n_ms  = ms_probe;
      n_dss = 1'b1;
      n_dg  = dy_hit && dy_ok;
      n_rem = (dy_hit && dy_ok) ? flen_c : MS_ONE;
      n_def = dy_hit && !dy_ok;
    end
    if (go_cycle) begin
      if (started) n_cyc = cycle_cnt + 1'b1;
      n_started = 1'b1;
      n_phase   = PH_ST;
      n_st      = SLOT_ONE;
      n_dy      = SLOT_ONE;
      n_ms      = MS_ONE;
      n_cs      = 1'b1;
      n_sss     = 1'b1;
      n_sg      = st_hit;
      n_dg      = 1'b0;
      n_rem     = MS_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase         <= PH_WAIT;
      started       <= 1'b0;
      rem           <= MS_ONE;
      cycle_cnt     <= '0;
      st_slot       <= SLOT_ONE;
      dy_slot       <= SLOT_ONE;
      minislot      <= MS_ONE;
      in_dynamic    <= 1'b0;
      st_grant      <= 1'b0;
      dy_grant      <= 1'b0;
      cycle_start   <= 1'b0;
      st_slot_start <= 1'b0;
      dy_slot_start <= 1'b0;
      dy_defer      <= 1'b0;
      cfg_err       <= 1'b0;
    end else begin
      phase         <= n_phase;
      started       <= n_started;
      rem           <= n_rem;
      cycle_cnt     <= n_cyc;
      st_slot       <= n_st;
      dy_slot       <= n_dy;
      minislot      <= n_ms;
      in_dynamic    <= (n_phase == PH_DY);
      st_grant      <= n_sg;
      dy_grant      <= n_dg;
      cycle_start   <= n_cs;
      st_slot_start <= n_sss;
      dy_slot_start <= n_dss;
      dy_defer      <= n_def;
      cfg_err       <= (cfg_num_static == '0);
    end
  end
endmodule

// File: rtl/tt_arb_chk.sv
module tt_arb_chk #(
  parameter int SLOT_W = 6,
  parameter int MS_W   = 8,
  parameter int CYC_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [MS_W-1:0]   cfg_latest_tx,
  input logic [CYC_W-1:0]  cycle_cnt,
  input logic [SLOT_W-1:0] st_slot,
  input logic [MS_W-1:0]   minislot,
  input logic              st_grant,
  input logic              dy_grant,
  input logic              cycle_start,
  input logic              st_slot_start,
  input logic              dy_slot_start,
  input logic              dy_defer,
  input logic              cfg_err
);
  logic seen_start;
  always_ff @(posedge clk) begin
    if (rst)              seen_start <= 1'b0;
    else if (cycle_start) seen_start <= 1'b1;
  end

  // R4
  cyc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (st_slot == SLOT_W'(1) && minislot == MS_W'(1)));

  // R3
  cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && seen_start) |-> cycle_cnt == CYC_W'($past(cycle_cnt) + 1'b1));

  // R5
  grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_grant && dy_grant));

  // R7
  dy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dy_grant) |-> (dy_slot_start && minislot < cfg_latest_tx));

  // R8
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    dy_defer |-> (dy_slot_start && !dy_grant));

  // R9
  st_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_slot_start && !cycle_start) |-> st_slot == SLOT_W'($past(st_slot) + 1'b1));

  // R10
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err && !seen_start) |-> !(st_grant || dy_grant || st_slot_start || dy_slot_start));
endmodule

bind tt_slot_arbiter tt_arb_chk #(
  .SLOT_W(SLOT_W), .MS_W(MS_W), .CYC_W(CYC_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_latest_tx (cfg_latest_tx),
  .cycle_cnt     (cycle_cnt),
  .st_slot       (st_slot),
  .minislot      (minislot),
  .st_grant      (st_grant),
  .dy_grant      (dy_grant),
  .cycle_start   (cycle_start),
  .st_slot_start (st_slot_start),
  .dy_slot_start (dy_slot_start),
  .dy_defer      (dy_defer),
  .cfg_err       (cfg_err)
);

// File: tb/sim_tt_slot_arbiter.sv
`timescale 1ns/1ps
module sim_tt_slot_arbiter;
  localparam int TICK_W = 8, SLOT_W = 6, MS_W = 8, CYC_W = 6, N_ST = 4, N_DY = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [TICK_W-1:0] cfg_slot_len, cfg_minislot_len;
  logic [SLOT_W-1:0] cfg_num_static;
  logic [MS_W-1:0]   cfg_num_minislots, cfg_latest_tx, dy_frame_len;
  logic [SLOT_W-1:0] stid [N_ST];
  logic [SLOT_W-1:0] dyid [N_DY];
  logic [N_DY-1:0]   dy_pending;
  logic [N_ST*SLOT_W-1:0] st_ids;
  logic [N_DY*SLOT_W-1:0] dy_ids;
  assign st_ids = {stid[3], stid[2], stid[1], stid[0]};
  assign dy_ids = {dyid[3], dyid[2], dyid[1], dyid[0]};

  logic [CYC_W-1:0]  cycle_cnt;
  logic [SLOT_W-1:0] st_slot, dy_slot;
  logic [MS_W-1:0]   minislot;
  logic in_dynamic, st_grant, dy_grant, cycle_start, st_slot_start, dy_slot_start, dy_defer, cfg_err;

  tt_slot_arbiter u0 (
    .clk(clk), .rst(rst), .cfg_slot_len(cfg_slot_len), .cfg_num_static(cfg_num_static),
    .cfg_num_minislots(cfg_num_minislots), .cfg_minislot_len(cfg_minislot_len),
    .cfg_latest_tx(cfg_latest_tx), .st_ids(st_ids), .dy_ids(dy_ids),
    .dy_pending(dy_pending), .dy_frame_len(dy_frame_len), .cycle_cnt(cycle_cnt),
    .st_slot(st_slot), .dy_slot(dy_slot), .minislot(minislot), .in_dynamic(in_dynamic),
    .st_grant(st_grant), .dy_grant(dy_grant), .cycle_start(cycle_start),
    .st_slot_start(st_slot_start), .dy_slot_start(dy_slot_start), .dy_defer(dy_defer),
    .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  int ticks  = 0;

  // ---- expected-behaviour model (from the requirements) ----
  int e_ph, e_tick, e_cyc, e_st, e_dy, e_ms, e_rem;
  bit e_started, e_sg, e_dg, e_cs, e_sss, e_dss, e_def, e_err;

  function automatic int clamp1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit owns_static(input int s);
    for (int i = 0; i < N_ST; i++)
      if (stid[i] != 0 && int'(stid[i]) == s) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit wants_dynamic(input int s);
    for (int i = 0; i < N_DY; i++)
      if (dy_pending[i] && dyid[i] != 0 && int'(dyid[i]) == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_new_cycle();
    if (e_started) e_cyc = (e_cyc + 1) % 64;
    e_started = 1; e_ph = 1; e_tick = 0;
    e_st = 1; e_dy = 1; e_ms = 1;
    e_cs = 1; e_sss = 1; e_sg = owns_static(1); e_dg = 0;
  endtask

  task automatic m_dyn_slot();
    bit want, room;
    want  = wants_dynamic(e_dy);
    room  = e_ms < int'(cfg_latest_tx);
    e_dss = 1;
    e_dg  = want && room;
    e_rem = (want && room) ? clamp1(int'(dy_frame_len)) : 1;
    e_def = want && !room;
  endtask

  task automatic model_step();
    if (rst) begin
      e_ph = 0; e_tick = 0; e_cyc = 0; e_st = 1; e_dy = 1; e_ms = 1; e_rem = 1;
      e_started = 0; e_sg = 0; e_dg = 0; e_cs = 0; e_sss = 0; e_dss = 0; e_def = 0; e_err = 0;
      return;
    end
    e_cs = 0; e_sss = 0; e_dss = 0; e_def = 0;
    e_err = (cfg_num_static == 0);
    case (e_ph)
      0: if (cfg_num_static != 0) m_new_cycle();
      1: begin
        if (e_tick == clamp1(int'(cfg_slot_len)) - 1) begin
          e_tick = 0;
          if (e_st == int'(cfg_num_static)) begin
            e_sg = 0;
            if (cfg_num_minislots == 0) m_new_cycle();
            else begin e_ph = 2; e_dy = 1; e_ms = 1; m_dyn_slot(); end
          end else begin
            e_st = e_st + 1; e_sss = 1; e_sg = owns_static(e_st);
          end
        end else e_tick++;
      end
      default: begin
        if (e_tick == clamp1(int'(cfg_minislot_len)) - 1) begin
          e_tick = 0;
          if (e_ms == int'(cfg_num_minislots)) begin
            e_dg = 0; m_new_cycle();
          end else begin
            e_ms++;
            if (e_rem <= 1) begin e_dy = (e_dy + 1) % 64; m_dyn_slot(); end
            else e_rem--;
          end
        end else e_tick++;
      end
    endcase
  endtask

  always @(posedge clk) model_step();

  // ---- checking ----
  task automatic fld(input string scen, input string tag, input int got, input int exp, inout bit bad);
    if (got != exp) begin
      $display("FAIL %s %s got %0d exp %0d at tick %0d", scen, tag, got, exp, ticks);
      bad = 1'b1;
    end
  endtask

  task automatic compare(input string scen);
    bit bad = 1'b0;
    fld(scen, "R3 cycle_cnt", int'(cycle_cnt), e_cyc, bad);
    fld(scen, "R2 st_slot", int'(st_slot), e_st, bad);
    fld(scen, "R6/R7 dy_slot", int'(dy_slot), e_dy, bad);
    fld(scen, "R3 minislot", int'(minislot), e_ms, bad);
    fld(scen, "R2 in_dynamic", int'(in_dynamic), (e_ph == 2) ? 1 : 0, bad);
    fld(scen, "R5 st_grant", int'(st_grant), int'(e_sg), bad);
    fld(scen, "R7 dy_grant", int'(dy_grant), int'(e_dg), bad);
    fld(scen, "R4 cycle_start", int'(cycle_start), int'(e_cs), bad);
    fld(scen, "R9 st_slot_start", int'(st_slot_start), int'(e_sss), bad);
    fld(scen, "R9 dy_slot_start", int'(dy_slot_start), int'(e_dss), bad);
    fld(scen, "R8 dy_defer", int'(dy_defer), int'(e_def), bad);
    fld(scen, "R10 cfg_err", int'(cfg_err), int'(e_err), bad);
    checks++;
    if (bad) errors++;
  endtask

  task automatic step_cmp(input string scen, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      ticks++;
      compare(scen);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input int sl, input int ns, input int nm, input int ml, input int lt);
    cfg_slot_len = TICK_W'(sl); cfg_num_static = SLOT_W'(ns); cfg_num_minislots = MS_W'(nm);
    cfg_minislot_len = TICK_W'(ml); cfg_latest_tx = MS_W'(lt);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED1);
    set_cfg(3, 3, 8, 2, 6);
    for (int i = 0; i < N_ST; i++) stid[i] = '0;
    for (int i = 0; i < N_DY; i++) dyid[i] = '0;
    dy_pending = '0; dy_frame_len = MS_W'(3);
    stid[0] = 6'd2; dyid[0] = 6'd1; dyid[1] = 6'd3;
    dy_pending = 4'b0011;

    // R1: reset state, sampled while reset is high
    repeat (2) @(negedge clk);
    checks++;
    if (cycle_cnt != 0 || st_slot != 1 || dy_slot != 1 || minislot != 1 || st_grant || dy_grant ||
        cycle_start || st_slot_start || dy_slot_start || dy_defer || cfg_err || in_dynamic) begin
      errors++;
      $display("FAIL R1 reset state got cyc=%0d st=%0d dy=%0d ms=%0d exp 0/1/1/1 flags 0",
               cycle_cnt, st_slot, dy_slot, minislot);
    end
    rst = 1'b0;

    // R2 R5 R7 R9: directed static/dynamic grants
    step_cmp("R2 R5 R7 R9 directed", 150);

    // R8: late limit defers dynamic id 3
    do_reset(); set_cfg(2, 2, 10, 1, 3); dy_frame_len = MS_W'(2);
    step_cmp("R8 deferral", 120);

    // R11: long frame cut off at segment end
    do_reset(); set_cfg(1, 1, 4, 2, 4); dyid[0] = 6'd1; dy_pending = 4'b0001;
    dy_frame_len = MS_W'(10);
    step_cmp("R11 truncation", 60);

    // R6: nothing pending, idle slots one minislot each; frame length 0 treated as 1
    do_reset(); set_cfg(2, 2, 6, 3, 6); dy_pending = '0; dy_frame_len = '0;
    step_cmp("R6 idle dynamic", 60);
    dy_pending = 4'b0001;
    step_cmp("R7 zero frame length", 60);

    // R3 R4: one-tick cycles to reach the 63->0 wrap
    do_reset(); set_cfg(1, 1, 0, 1, 1);
    step_cmp("R3 R4 wrap", 140);

    // R10: zero static slots, then recovery without reset
    do_reset(); set_cfg(2, 0, 3, 1, 3);
    step_cmp("R10 cfg error", 20);
    checks++;
    if (!cfg_err || cycle_start || st_slot != 1 || cycle_cnt != 0) begin
      errors++;
      $display("FAIL R10 idle with zero slots got err=%0d cs=%0d st=%0d exp 1/0/1", cfg_err, cycle_start, st_slot);
    end
    cfg_num_static = SLOT_W'(2);
    step_cmp("R10 recovery", 40);

    // Random configurations
    for (int s = 0; s < 20; s++) begin
      do_reset();
      set_cfg($urandom_range(0, 4), $urandom_range(1, 5), $urandom_range(0, 12),
              $urandom_range(0, 3), $urandom_range(1, 12));
      for (int i = 0; i < N_ST; i++) stid[i] = SLOT_W'($urandom_range(0, 6));
      for (int i = 0; i < N_DY; i++) dyid[i] = SLOT_W'(i * 3 + $urandom_range(1, 3));
      dy_pending = N_DY'($urandom_range(0, 15));
      for (int k = 0; k < 10; k++) begin
        dy_frame_len = MS_W'($urandom_range(0, 4));
        step_cmp("R2 R5 R6 R7 R8 R9 random", 25);
        dy_pending = N_DY'($urandom_range(0, 15));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule